// File: doc/BRIEF.md
# Packed Calendar Counter with Alarm

This block keeps wall-clock time as a calendar. A one-cycle `tick` strobe, derived elsewhere from a 1 Hz prescaler, advances seconds, minutes, hours, the day of the week together with the day of the month, the month, and a four-digit BCD year. The time is held in one packed 32-bit word. The year is held in a separate 16-bit word. Month lengths follow the Gregorian leap rule, which is evaluated from the BCD year.

Software sets the time by writing two load registers. Both are applied at once on the next tick. An alarm compares the whole date and time, weekday and year included, against two match registers. A match latches a raw status bit. That bit drives the `irq` output only while the mask bit is set, and it stays latched until a write to the clear register removes it. A control bit gates counting. Register access uses a simple write strobe and a combinational read mux; the bus fabric sits outside.

Top module: `calWatch`

## Requirements
- R1: After reset the time word reads 0x02120000 (00:00:00, weekday 1, day 1, month 1), the year reads 0x2000, and the raw status, mask and `irq` are 0. Time word fields: second [5:0], minute [11:6], hour [16:12], weekday [19:17] with 1 = Sunday, day of month [24:20], month [28:25] with 1 = January.
- R2: On each counting tick the second increments. Second 59 wraps to 0 and carries into the minute, minute 59 wraps to 0 and carries into the hour, and hour 23 wraps to 0 and carries into the day.
- R3: A day carry advances the weekday and the day of month together. The weekday wraps from 7 to 1, and the day of month wraps to 1 after the month's last day, carrying into the month.
- R4: The month length is 31, 30 (April, June, September, November) or 28/29 (February). February has 29 days when the binary year is divisible by 4, except for century years not divisible by 400.
- R5: Month 12 wraps to 1 and increments the year. The year word holds the low two decimal digits as BCD in [7:0] and the century as BCD in [15:8]. 99 in the low byte carries into the century, and 9999 wraps to 0000.
- R6: Counting happens only while bit 26 of the control register (offset 0x0C) is 1. While it is 0, ticks leave the time and the year unchanged.
- R7: Writes to the time load register (0x08) or the year load register (0x38) have no visible effect until the next tick. On that tick both the time and the year are replaced by the load registers, even while counting is off, and the tick does not also count.
- R8: Bit 0 of the raw status register (0x14) is set when the time word and the year first equal the time match register (0x04) and the year match register (0x34). Every field must match, the weekday included.
- R9: `irq` and bit 0 of the masked status register (0x18) equal raw bit 0 AND mask bit 0 (mask register 0x10).
- R10: Raw bit 0 stays set until a write to the clear register (0x1C) has bit 0 set. A clear write with bit 0 at 0 has no effect.
- R11: Reads return the time at 0x00, the year at 0x30, both match registers, the control bit at bit 26 and the mask at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 1 Hz step strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| timeOut | output | 32 | Current packed time word |
| yearOut | output | 16 | Current BCD year |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The cases that are hardest to reach from the ports are the rare rollovers: month ends, February in leap and non-leap years, century years and the 9999 wrap. Reaching them by counting would take millions of ticks. The bench instead loads 23:59:59 on the last day of every month in a spread of years, then ticks once and compares the result with an arithmetic calendar model. A long counting run through a leap-day midnight covers the second, minute and hour chain. The alarm is driven to fire with a correct weekday and kept from firing with a wrong one.

// File: rtl/calPkg.sv
package calPkg;
  localparam int TIME_W  = 32;
  localparam int YEAR_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int SEC_LO  = 0;
  localparam int SEC_W   = 6;
  localparam int MIN_LO  = 6;
  localparam int MIN_W   = 6;
  localparam int HOUR_LO = 12;
  localparam int HOUR_W  = 5;
  localparam int WDAY_LO = 17;
  localparam int WDAY_W  = 3;
  localparam int MDAY_LO = 20;
  localparam int MDAY_W  = 5;
  localparam int MON_LO  = 25;
  localparam int MON_W   = 4;
  localparam int CW_BIT  = 26;

  localparam logic [ADDR_W-1:0] OFS_TIME_RD    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_TIME_MATCH = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_TIME_LOAD  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL       = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK       = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_RAW        = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_MASKED     = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CLEAR      = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_YEAR_RD    = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_YEAR_MATCH = 6'h34;
  localparam logic [ADDR_W-1:0] OFS_YEAR_LOAD  = 6'h38;

  localparam logic [TIME_W-1:0] RESET_TIME = 32'h0212_0000;
  localparam logic [YEAR_W-1:0] RESET_YEAR = 16'h2000;

  typedef struct packed {
    logic wrTimeLoad;
    logic wrYearLoad;
    logic applyLoad;
    logic advance;
  } calStrobeT;

  function automatic logic [7:0] bcdToBin(input logic [7:0] b);
    return {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
  endfunction

  function automatic logic isLeap(input logic [15:0] y);
    logic [7:0] lo;
    logic [7:0] ce;
    lo = bcdToBin(y[7:0]);
    ce = bcdToBin(y[15:8]);
    return ((lo % 8'd4) == 8'd0) && ((lo != 8'd0) || ((ce % 8'd4) == 8'd0));
  endfunction

  function automatic logic [4:0] monthDays(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] b);
    logic [7:0] r;
    if (b[3:0] >= 4'd9) begin
      if (b[7:4] >= 4'd9) r = 8'h00;
      else                r = {b[7:4] + 4'd1, 4'd0};
    end else begin
      r = {b[7:4], b[3:0] + 4'd1};
    end
    return r;
  endfunction
endpackage

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobeT         stb,
  input  logic [TIME_W-1:0] wrData,
  output logic [TIME_W-1:0] timeOut,
  output logic [YEAR_W-1:0] yearOut
);
  logic [TIME_W-1:0] timeQ, loadTimeQ, timeNext;
  logic [YEAR_W-1:0] yearQ, loadYearQ, yearNext;

  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  min;
  logic [HOUR_W-1:0] hour;
  logic [WDAY_W-1:0] wday;
  logic [MDAY_W-1:0] mday;
  logic [MON_W-1:0]  mon;
  logic [4:0]        monLen;
  logic c1, c2, c3, c4, c5;

  assign sec    = timeQ[SEC_LO  +: SEC_W];
  assign min    = timeQ[MIN_LO  +: MIN_W];
  assign hour   = timeQ[HOUR_LO +: HOUR_W];
  assign wday   = timeQ[WDAY_LO +: WDAY_W];
  assign mday   = timeQ[MDAY_LO +: MDAY_W];
  assign mon    = timeQ[MON_LO  +: MON_W];
  assign monLen = monthDays(mon, isLeap(yearQ));

  // carry chain: each stage wraps only when all lower stages wrap
  assign c1 = sec  >= 6'd59;
  assign c2 = c1 && (min  >= 6'd59);
  assign c3 = c2 && (hour >= 5'd23);
  assign c4 = c3 && (mday >= monLen);
  assign c5 = c4 && (mon  >= 4'd12);

  always_comb begin
    timeNext = timeQ;
    timeNext[SEC_LO  +: SEC_W]  = c1 ? '0 : sec + 6'd1;
    timeNext[MIN_LO  +: MIN_W]  = c1 ? (c2 ? '0 : min + 6'd1) : min;
    timeNext[HOUR_LO +: HOUR_W] = c2 ? (c3 ? '0 : hour + 5'd1) : hour;
    timeNext[WDAY_LO +: WDAY_W] = c3 ? ((wday >= 3'd7) ? 3'd1 : wday + 3'd1) : wday;
    timeNext[MDAY_LO +: MDAY_W] = c3 ? (c4 ? 5'd1 : mday + 5'd1) : mday;
    timeNext[MON_LO  +: MON_W]  = c4 ? (c5 ? 4'd1 : mon + 4'd1) : mon;
    yearNext = yearQ;
    if (c5) begin
      yearNext[7:0]  = bcdInc(yearQ[7:0]);
      yearNext[15:8] = (yearQ[7:0] == 8'h99) ? bcdInc(yearQ[15:8]) : yearQ[15:8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeQ     <= RESET_TIME;
      yearQ     <= RESET_YEAR;
      loadTimeQ <= RESET_TIME;
      loadYearQ <= RESET_YEAR;
    end else begin
      if (stb.wrTimeLoad) loadTimeQ <= wrData;
      if (stb.wrYearLoad) loadYearQ <= wrData[YEAR_W-1:0];
      if (stb.applyLoad) begin
        timeQ <= loadTimeQ;
        yearQ <= loadYearQ;
      end else if (stb.advance) begin
        timeQ <= timeNext;
        yearQ <= yearNext;
      end
    end
  end

  assign timeOut = timeQ;
  assign yearOut = yearQ;

  AST_TICK_MOVES_SECONDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> sec != $past(sec));  // R2
  AST_DAY_AND_WEEKDAY_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> ((mday != $past(mday)) == (wday != $past(wday))));  // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.applyLoad) |=> ($stable(timeQ) && $stable(yearQ)));  // R6
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.applyLoad |=> (timeQ == $past(loadTimeQ) && yearQ == $past(loadYearQ)));  // R7
endmodule

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TIME_W-1:0] regWrData,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [YEAR_W-1:0] yearNow,
  output calStrobeT         stb,
  output logic              cwEn,
  output logic [TIME_W-1:0] matchTime,
  output logic [YEAR_W-1:0] matchYear,
  output logic              maskBit,
  output logic              rawBit,
  output logic              irq
);
  logic pendQ, hitPrevQ, hitNow, clrHit, loadWr;
  logic cwEnQ, maskQ, rawQ;
  logic [TIME_W-1:0] matchTimeQ;
  logic [YEAR_W-1:0] matchYearQ;

  always_comb begin
    stb            = '0;
    stb.wrTimeLoad = regWrEn && (regAddr == OFS_TIME_LOAD);
    stb.wrYearLoad = regWrEn && (regAddr == OFS_YEAR_LOAD);
    stb.applyLoad  = tick && pendQ;
    stb.advance    = tick && cwEnQ && !pendQ;
  end

  assign loadWr = stb.wrTimeLoad || stb.wrYearLoad;
  assign clrHit = regWrEn && (regAddr == OFS_CLEAR) && regWrData[0];
  assign hitNow = (timeNow == matchTimeQ) && (yearNow == matchYearQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ      <= 1'b0;
      hitPrevQ   <= 1'b0;
      cwEnQ      <= 1'b0;
      maskQ      <= 1'b0;
      rawQ       <= 1'b0;
      matchTimeQ <= '0;
      matchYearQ <= '0;
    end else begin
      if (loadWr)    pendQ <= 1'b1;
      else if (tick) pendQ <= 1'b0;
      hitPrevQ <= hitNow;
      if (hitNow && !hitPrevQ) rawQ <= 1'b1;
      else if (clrHit)         rawQ <= 1'b0;
      if (regWrEn) begin
        case (regAddr)
          OFS_CTRL:       cwEnQ      <= regWrData[CW_BIT];
          OFS_MASK:       maskQ      <= regWrData[0];
          OFS_TIME_MATCH: matchTimeQ <= regWrData;
          OFS_YEAR_MATCH: matchYearQ <= regWrData[YEAR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign cwEn      = cwEnQ;
  assign matchTime = matchTimeQ;
  assign matchYear = matchYearQ;
  assign maskBit   = maskQ;
  assign rawBit    = rawQ;
  assign irq       = rawQ && maskQ;

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.advance, stb.applyLoad}));  // R7
  AST_HALT_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    !cwEnQ |-> !stb.advance);  // R6
  AST_MATCH_SETS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (hitNow && !hitPrevQ) |=> rawQ);  // R8
  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rawQ && !clrHit) |=> rawQ);  // R10
endmodule

// File: rtl/calWatch.sv
module calWatch
  import calPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TIME_W-1:0] regWrData,
  output logic [TIME_W-1:0] regRdData,
  output logic [TIME_W-1:0] timeOut,
  output logic [YEAR_W-1:0] yearOut,
  output logic              irq
);
  calStrobeT         stb;
  logic              cwEn, maskBit, rawBit;
  logic [TIME_W-1:0] matchTime;
  logic [YEAR_W-1:0] matchYear;

  calCtrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .timeNow(timeOut), .yearNow(yearOut), .stb(stb),
    .cwEn(cwEn), .matchTime(matchTime), .matchYear(matchYear),
    .maskBit(maskBit), .rawBit(rawBit), .irq(irq)
  );

  calDatapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .timeOut(timeOut), .yearOut(yearOut)
  );

  always_comb begin
    case (regAddr)
      OFS_TIME_RD:    regRdData = timeOut;
      OFS_TIME_MATCH: regRdData = matchTime;
      OFS_CTRL:       regRdData = TIME_W'(cwEn) << CW_BIT;
      OFS_MASK:       regRdData = TIME_W'(maskBit);
      OFS_RAW:        regRdData = TIME_W'(rawBit);
      OFS_MASKED:     regRdData = TIME_W'(irq);
      OFS_YEAR_RD:    regRdData = TIME_W'(yearOut);
      OFS_YEAR_MATCH: regRdData = TIME_W'(matchYear);
      default:        regRdData = '0;
    endcase
  end
endmodule

// File: tb/sim_calWatch.sv
module sim_calWatch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, timeOut;
  logic [15:0] yearOut;
  logic irq;
  int nChk = 0;
  int nErr = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  calWatch u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timeOut(timeOut),
    .yearOut(yearOut), .irq(irq)
  );

  task automatic chk(input string req, input logic [47:0] got, input logic [47:0] exp);
    nChk++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic int bcd2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int mlen(input int m, input int yr);
    bit leap = (yr % 4 == 0) && ((yr % 100 != 0) || (yr % 400 == 0));
    if (m == 2) return leap ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [31:0] mk(input int mo, input int md, input int wd,
                                     input int h, input int mi, input int s);
    return {3'd0, 4'(mo), 5'(md), 3'(wd), 5'(h), 6'(mi), 6'(s)};
  endfunction
  // reference calendar step: returns {year, time}
  function automatic logic [47:0] refNext(input logic [15:0] y, input logic [31:0] t);
    int s  = int'(t[5:0]);
    int mi = int'(t[11:6]);
    int h  = int'(t[16:12]);
    int wd = int'(t[19:17]);
    int md = int'(t[24:20]);
    int mo = int'(t[28:25]);
    int yr = bcd2i(y[15:8]) * 100 + bcd2i(y[7:0]);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; wd = (wd % 7) + 1; md++;
          if (md > mlen(mo, yr)) begin
            md = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 10000; end
          end
        end
      end
    end
    return {i2bcd(yr / 100), i2bcd(yr % 100), mk(mo, md, wd, h, mi, s)};
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nChk++; nErr++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
        finishRun();
      end
    end
  end

  logic [15:0] yrs [6] = '{16'h1900, 16'h2000, 16'h2023, 16'h2024, 16'h2099, 16'h9999};

  initial begin
    logic [31:0] d;
    logic [31:0] t;
    logic [47:0] exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", {16'd0, timeOut}, {16'd0, 32'h0212_0000});
    chk("R1 year", {32'd0, yearOut}, {32'd0, 16'h2000});
    chk("R1 irq", {47'd0, irq}, 48'd0);
    rdReg(6'h14, d); chk("R1 raw", {16'd0, d}, 48'd0);
    rdReg(6'h10, d); chk("R1 mask", {16'd0, d}, 48'd0);

    // R6 halted counting
    repeat (3) pulseTick();
    chk("R6 halted", {yearOut, timeOut}, {16'h2000, 32'h0212_0000});

    // R7 load held until tick, applied while halted
    t = mk(5, 17, 6, 8, 9, 10);
    wrReg(6'h08, t);
    wrReg(6'h38, 32'h0000_2031);
    repeat (4) @(negedge clk);
    chk("R7 held", {yearOut, timeOut}, {16'h2000, 32'h0212_0000});
    pulseTick();
    chk("R7 applied", {yearOut, timeOut}, {16'h2031, t});
    pulseTick();
    chk("R6 halted after load", {yearOut, timeOut}, {16'h2031, t});

    // enable counting
    wrReg(6'h0C, 32'h1 << 26);
    rdReg(6'h0C, d); chk("R11 ctrl", {16'd0, d}, {16'd0, 32'h0400_0000});

    // R2 long run through leap-day midnight
    t = mk(2, 28, 4, 23, 30, 0);
    wrReg(6'h08, t);
    wrReg(6'h38, 32'h2024);
    pulseTick();
    chk("R7 applied with counting on", {yearOut, timeOut}, {16'h2024, t});
    exp = {16'h2024, t};
    for (int i = 0; i < 4000; i++) begin
      pulseTick();
      exp = refNext(exp[47:32], exp[31:0]);
      chk("R2 run", {yearOut, timeOut}, exp);
    end

    // R3 R4 R5 month-end sweep
    foreach (yrs[k]) begin
      for (int m = 1; m <= 12; m++) begin
        int yi = bcd2i(yrs[k][15:8]) * 100 + bcd2i(yrs[k][7:0]);
        t = mk(m, mlen(m, yi), ((m - 1) % 7) + 1, 23, 59, 59);
        wrReg(6'h08, t);
        wrReg(6'h38, {16'd0, yrs[k]});
        pulseTick();
        chk("R7 sweep load", {yearOut, timeOut}, {yrs[k], t});
        pulseTick();
        exp = refNext(yrs[k], t);
        chk(m == 12 ? "R5 year end" : (m == 2 ? "R4 february" : "R3 month end"),
            {yearOut, timeOut}, exp);
      end
    end

    // R8 R9 R10 alarm
    t = mk(6, 15, 3, 10, 20, 30);
    wrReg(6'h04, mk(6, 15, 3, 10, 20, 32));
    wrReg(6'h34, 32'h2024);
    wrReg(6'h08, t);
    wrReg(6'h38, 32'h2024);
    pulseTick();
    pulseTick();
    repeat (2) @(negedge clk);
    rdReg(6'h14, d); chk("R8 no early match", {16'd0, d}, 48'd0);
    pulseTick();
    repeat (2) @(negedge clk);
    rdReg(6'h14, d); chk("R8 match raw", {16'd0, d}, 48'd1);
    chk("R9 masked irq low", {47'd0, irq}, 48'd0);
    rdReg(6'h18, d); chk("R9 masked status low", {16'd0, d}, 48'd0);
    wrReg(6'h10, 32'h1);
    chk("R9 irq high", {47'd0, irq}, 48'd1);
    rdReg(6'h18, d); chk("R9 masked status high", {16'd0, d}, 48'd1);
    wrReg(6'h1C, 32'h0);
    rdReg(6'h14, d); chk("R10 clear zero ignored", {16'd0, d}, 48'd1);
    wrReg(6'h1C, 32'h1);
    rdReg(6'h14, d); chk("R10 cleared", {16'd0, d}, 48'd0);
    chk("R10 irq dropped", {47'd0, irq}, 48'd0);

    // R8 weekday mismatch never fires
    wrReg(6'h08, mk(6, 15, 4, 10, 20, 30));
    pulseTick();
    repeat (4) pulseTick();
    repeat (2) @(negedge clk);
    rdReg(6'h14, d); chk("R8 weekday mismatch", {16'd0, d}, 48'd0);
    chk("R8 irq quiet", {47'd0, irq}, 48'd0);

    // R11 readback
    rdReg(6'h04, d); chk("R11 time match", {16'd0, d}, {16'd0, mk(6, 15, 3, 10, 20, 32)});
    rdReg(6'h34, d); chk("R11 year match", {16'd0, d}, 48'h2024);
    rdReg(6'h10, d); chk("R11 mask", {16'd0, d}, 48'd1);
    rdReg(6'h00, d); chk("R11 time read", {16'd0, d}, {16'd0, timeOut});
    rdReg(6'h30, d); chk("R11 year read", {16'd0, d}, 48'h2024);

    finishRun();
  end
endmodule